// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them by a fixed priority and raises a single interrupt to the processor. When the processor acknowledges, the block answers with an 8-bit vector. The upper five bits of the vector come from a programmed base, and the lower three bits give the winning line. At the same moment the block moves that line from its pending set into its in-service set. Software programs the block through a byte-wide port with one address bit. A short initialization sequence comes first. After it, command bytes clear in-service bits, choose what reads return, and change the mask.

Two of these controllers can be chained. In that arrangement one acts as master and one as slave. The master knows which of its lines carry a slave. When it acknowledges such a line, it publishes the line number instead of a vector. A slave answers an acknowledge only when the cascade number it receives matches its programmed identity.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF at address 1, a read at address 0 returns the request register (0x00), and `int_out` is low.
- R2: A write at address 0 with bit 4 set starts initialization. The next address-1 write holds the vector base in bits 7:3. A cascade-line word follows only if bit 1 of the start byte was 0. A mode word follows only if bit 0 of the start byte was 1. `int_out` stays low until the sequence ends.
- R3: In the mode word, bit 1 = 1 selects automatic end-of-interrupt, and the in-service bit is then never left set by an acknowledge. Bit 1 = 0 keeps normal end-of-interrupt.
- R4: After initialization, an address-1 write loads the mask and an address-1 read returns it. A set bit keeps that line from raising `int_out` or winning an acknowledge.
- R5: Writing 0x0B at address 0 makes address-0 reads return the in-service register. Writing 0x0A returns them to the request register. Starting initialization also selects the request register.
- R6: A request bit is set one clock after its line rises, stays set while the line is high, and is cleared once the line is sampled low.
- R7: Line 0 has the highest priority. `int_out` is high exactly when some unmasked request outranks every in-service bit.
- R8: An `inta` pulse with a winning request gives `vec_valid` on the next cycle with `vec_out` = base*8 + line. The same edge clears that request bit and sets its in-service bit.
- R9: An acknowledge with no qualifying request gives vector base*8 + 7 and leaves the in-service register unchanged. This holds even when line 7 is masked.
- R10: Command 0x60+L at address 0 clears in-service bit L. Command 0x20 clears the highest-priority in-service bit.
- R11: A master (`master_sel`=1, cascade mode) that acknowledges a line whose bit is set in the cascade-line word raises `cas_valid` with `cas_out` = line, not `vec_valid`. It still sets the in-service bit.
- R12: A slave (`master_sel`=0, cascade mode) acts on `inta` only when `cas_in` equals bits 2:0 of its cascade-line word. Otherwise it drives no output and keeps its request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to processor |
| inta | input | 1 | Acknowledge pulse |
| master_sel | input | 1 | 1 = master identity, 0 = slave |
| cas_in | input | 3 | Cascade number seen by a slave |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | 8 | Delivered vector |
| cas_valid | output | 1 | Master hands the acknowledge to a slave |
| cas_out | output | 3 | Line number of the addressed slave |

## Verification
The hardest case to reach from the ports is the spurious acknowledge. To set it up, a line must be seen pending, which raises `int_out`. The line must then drop, and `inta` must arrive only after the request bit has been cleared. The stimulus holds the request for one cycle, removes it for one cycle, and only then pulses `inta`. Line 7 is masked while this happens.

The nested case is reached by acknowledging a mid-priority line and then raising one line on each side of it. This shows the in-service set blocking the lower line and letting the higher line through. The slave-identity mismatch is reached by reinitializing the block as a slave and driving a wrong cascade number first.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int LINES  = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int BASE_W = DATA_W - IDX_W;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_BASE  = 2'd1,
    ST_CASC  = 2'd2,
    ST_MODE  = 2'd3
  } init_state_t;

  // Index of the lowest set bit; line 0 is the highest priority.
  function automatic logic [IDX_W-1:0] first_set(input logic [LINES-1:0] v);
    first_set = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) first_set = IDX_W'(i);
  endfunction

  // Isolates the highest-priority set bit as a one-hot mask.
  function automatic logic [LINES-1:0] top_bit(input logic [LINES-1:0] v);
    top_bit = v & (~v + LINES'(1));
  endfunction

  function automatic logic [LINES-1:0] line_mask(input logic [IDX_W-1:0] idx);
    line_mask = LINES'(1) << idx;
  endfunction

  function automatic logic [DATA_W-1:0] make_vector(input logic [BASE_W-1:0] base,
                                                    input logic [IDX_W-1:0] idx);
    make_vector = {base, idx};
  endfunction
endpackage

// File: rtl/pic8_regport.sv
module pic8_regport
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              a0,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              single_mode,
  output logic              aeoi,
  output logic [DATA_W-1:0] casc_cfg,
  output logic [BASE_W-1:0] vec_base,
  output logic [LINES-1:0]  imr,
  output logic              rd_isr,
  output logic              init_start,
  output logic              eoi_spec,
  output logic              eoi_nonspec,
  output logic [IDX_W-1:0]  eoi_line
);
  init_state_t state;
  logic        need_mode;
  logic        cmd_wr;
  logic        ocw2_wr;
  logic        ocw3_wr;

  assign init_start  = wr_en & ~a0 & wdata[4];
  assign ready       = (state == ST_READY);
  assign cmd_wr      = wr_en & ready & ~init_start;
  assign ocw2_wr     = cmd_wr & ~a0 & ~wdata[3];
  assign ocw3_wr     = cmd_wr & ~a0 & wdata[3];
  assign eoi_spec    = ocw2_wr & (wdata[7:5] == 3'b011);
  assign eoi_nonspec = ocw2_wr & (wdata[7:5] == 3'b001);
  assign eoi_line    = wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_READY;
      need_mode   <= 1'b0;
      single_mode <= 1'b1;
      aeoi        <= 1'b0;
      casc_cfg    <= '0;
      vec_base    <= '0;
      imr         <= '1;
      rd_isr      <= 1'b0;
    end else if (init_start) begin
      state       <= ST_BASE;
      single_mode <= wdata[1];
      need_mode   <= wdata[0];
      rd_isr      <= 1'b0;
      if (!wdata[0]) aeoi <= 1'b0;
    end else if (wr_en && a0) begin
      unique case (state)
        ST_BASE: begin
          vec_base <= wdata[DATA_W-1:IDX_W];
          if (!single_mode)   state <= ST_CASC;
          else if (need_mode) state <= ST_MODE;
          else                state <= ST_READY;
        end
        ST_CASC: begin
          casc_cfg <= wdata;
          state    <= need_mode ? ST_MODE : ST_READY;
        end
        ST_MODE: begin
          aeoi  <= wdata[1];
          state <= ST_READY;
        end
        default: imr <= wdata;
      endcase
    end else if (ocw3_wr && wdata[1]) begin
      rd_isr <= wdata[0];
    end
  end
endmodule

// File: rtl/pic8_reqstate.sv
module pic8_reqstate
  import pic8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq,
  input  logic             clear_all,
  input  logic [LINES-1:0] take_mask,
  input  logic [LINES-1:0] set_mask,
  input  logic [LINES-1:0] eoi_mask,
  output logic [LINES-1:0] irr,
  output logic [LINES-1:0] isr
);
  logic [LINES-1:0] line_q;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic req_next;
      // Set on a rising edge, held while high, dropped when the line falls.
      assign req_next = irq[g] & (irr[g] | ~line_q[g]) & ~take_mask[g];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          line_q[g] <= 1'b0;
          irr[g]    <= 1'b0;
          isr[g]    <= 1'b0;
        end else begin
          line_q[g] <= irq[g];
          if (clear_all) begin
            irr[g] <= 1'b0;
            isr[g] <= 1'b0;
          end else begin
            irr[g] <= req_next;
            isr[g] <= (isr[g] & ~eoi_mask[g]) | set_mask[g];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pic8_resolver.sv
module pic8_resolver
  import pic8_pkg::*;
(
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] isr,
  input  logic [LINES-1:0] imr,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx
);
  logic [LINES-1:0] pend;

  assign pend      = irr & ~imr;
  assign win_idx   = first_set(pend);
  assign win_valid = (|pend) && ((isr == '0) || (win_idx < first_set(isr)));
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              a0,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [LINES-1:0]  irq,
  output logic              int_out,
  input  logic              inta,
  input  logic              master_sel,
  input  logic [IDX_W-1:0]  cas_in,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_out,
  output logic              cas_valid,
  output logic [IDX_W-1:0]  cas_out
);
  logic              ready, single_mode, aeoi, rd_isr, init_start;
  logic              eoi_spec, eoi_nonspec;
  logic [IDX_W-1:0]  eoi_line;
  logic [DATA_W-1:0] casc_cfg;
  logic [BASE_W-1:0] vec_base;
  logic [LINES-1:0]  imr, irr, isr;
  logic              win_valid;
  logic [IDX_W-1:0]  win_idx;

  // Named internal events, also used by the checker.
  logic              ack_take, ack_real, ack_spur, to_slave, isr_clr;
  logic [LINES-1:0]  take_mask, set_mask, eoi_mask;

  pic8_regport u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wdata(wdata),
    .ready(ready), .single_mode(single_mode), .aeoi(aeoi),
    .casc_cfg(casc_cfg), .vec_base(vec_base), .imr(imr), .rd_isr(rd_isr),
    .init_start(init_start), .eoi_spec(eoi_spec), .eoi_nonspec(eoi_nonspec),
    .eoi_line(eoi_line)
  );

  pic8_resolver u_prio (
    .irr(irr), .isr(isr), .imr(imr), .win_valid(win_valid), .win_idx(win_idx)
  );

  assign ack_take  = inta & ready &
                     (single_mode | master_sel | (cas_in == casc_cfg[IDX_W-1:0]));
  assign ack_real  = ack_take & win_valid;
  assign ack_spur  = ack_take & ~win_valid;
  assign to_slave  = ack_real & ~single_mode & master_sel & casc_cfg[win_idx];
  assign take_mask = ack_real ? line_mask(win_idx) : '0;
  assign set_mask  = aeoi ? '0 : take_mask;
  assign eoi_mask  = eoi_spec    ? line_mask(eoi_line) :
                     eoi_nonspec ? top_bit(isr) : '0;
  assign isr_clr   = init_start | (|eoi_mask);

  pic8_reqstate u_state (
    .clk(clk), .rst_n(rst_n), .irq(irq), .clear_all(init_start),
    .take_mask(take_mask), .set_mask(set_mask), .eoi_mask(eoi_mask),
    .irr(irr), .isr(isr)
  );

  assign int_out = ready & win_valid;
  assign rdata   = a0 ? imr : (rd_isr ? isr : irr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_out   <= '0;
      cas_valid <= 1'b0;
      cas_out   <= '0;
    end else begin
      vec_valid <= ack_take & ~to_slave;
      cas_valid <= to_slave;
      if (ack_take) begin
        vec_out <= make_vector(vec_base, ack_real ? win_idx : IDX_W'(LINES - 1));
        cas_out <= win_idx;
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk
  import pic8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              int_out,
  input logic              ready,
  input logic              aeoi,
  input logic [LINES-1:0]  irr,
  input logic [LINES-1:0]  isr,
  input logic [LINES-1:0]  imr,
  input logic              ack_real,
  input logic              ack_spur,
  input logic              isr_clr,
  input logic [IDX_W-1:0]  win_idx,
  input logic              vec_valid,
  input logic [DATA_W-1:0] vec_out,
  input logic              cas_valid
);
  p_mask_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> imr == '1);

  p_quiet_in_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ready);

  p_aeoi_keeps_isr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_real && aeoi && !isr_clr |=> isr == $past(isr));

  p_int_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != '0);

  p_ack_sets_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_real && !aeoi && !isr_clr |=> isr[$past(win_idx)]);

  p_ack_clears_irr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_real |=> !irr[$past(win_idx)]);

  p_spur_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_spur |=> vec_valid && vec_out[IDX_W-1:0] == IDX_W'(LINES - 1));

  p_spur_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_spur && !isr_clr |=> isr == $past(isr));

  p_one_responder_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vec_valid, cas_valid}));
endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (.*);

// File: tb/pic8_ctrl_test.sv
module pic8_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       a0 = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq = 8'h00;
  logic       int_out;
  logic       inta = 1'b0;
  logic       master_sel = 1'b1;
  logic [2:0] cas_in = 3'd0;
  logic       vec_valid;
  logic [7:0] vec_out;
  logic       cas_valid;
  logic [2:0] cas_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pic8_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wdata(wdata),
    .rdata(rdata), .irq(irq), .int_out(int_out), .inta(inta),
    .master_sel(master_sel), .cas_in(cas_in), .vec_valid(vec_valid),
    .vec_out(vec_out), .cas_valid(cas_valid), .cas_out(cas_out)
  );

  // {mask, lines, expected int_out, expected vector}
  localparam logic [24:0] TBL [0:5] = '{
    {8'h00, 8'h81, 1'b1, 8'h20},
    {8'h01, 8'h81, 1'b1, 8'h27},
    {8'h00, 8'h30, 1'b1, 8'h24},
    {8'h10, 8'h30, 1'b1, 8'h25},
    {8'hFF, 8'hFF, 1'b0, 8'h00},
    {8'h00, 8'h08, 1'b1, 8'h23}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic addr, input logic [7:0] d);
    a0 = addr; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic addr, output logic [7:0] d);
    a0 = addr;
    #1 d = rdata;
  endtask

  task automatic ack(input logic [2:0] cin);
    cas_in = cin; inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
  endtask

  initial begin
    logic [7:0] r;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(1'b1, r); check("R1 mask reset", r, 8'hFF);
    rd(1'b0, r); check("R1 request readback", r, 8'h00);
    check("R1 int_out low", {7'd0, int_out}, 8'h00);

    // master, cascade on line 2, base 0x20, normal EOI
    master_sel = 1'b1;
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);

    // table walk: R4 R7 R8 R5 R10
    for (int k = 0; k < 6; k++) begin
      logic [7:0] msk, pat, ev;
      logic       ei;
      {msk, pat, ei, ev} = TBL[k];
      wr(1'b1, msk);
      rd(1'b1, r); check("R4 mask readback", r, msk);
      irq = pat;
      step(1);
      check("R7 int_out by priority/mask", {7'd0, int_out}, {7'd0, ei});
      if (ei) begin
        ack(3'd0);
        check("R8 vec_valid", {7'd0, vec_valid}, 8'h01);
        check("R8 vector", vec_out, ev);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); check("R5 in-service readback", r, 8'h01 << ev[2:0]);
        wr(1'b0, 8'h60 | {5'd0, ev[2:0]});
        rd(1'b0, r); check("R10 specific EOI", r, 8'h00);
        wr(1'b0, 8'h0A);
      end
      irq = 8'h00;
      step(1);
    end

    // R6 request capture and withdrawal
    irq = 8'h02; step(1);
    rd(1'b0, r); check("R6 request set", r, 8'h02);
    irq = 8'h00; step(1);
    rd(1'b0, r); check("R6 request dropped", r, 8'h00);

    // R7 R10 nesting
    wr(1'b1, 8'h00);
    irq = 8'h20; step(1);
    ack(3'd0); check("R8 line5 vector", vec_out, 8'h25);
    irq = 8'h60; step(1);
    check("R7 lower blocked by in-service", {7'd0, int_out}, 8'h00);
    irq = 8'h62; step(1);
    check("R7 higher passes in-service", {7'd0, int_out}, 8'h01);
    ack(3'd0); check("R8 line1 vector", vec_out, 8'h21);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R5 nested in-service", r, 8'h22);
    wr(1'b0, 8'h20);
    rd(1'b0, r); check("R10 non-specific EOI", r, 8'h20);
    check("R7 line6 still blocked", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h65);
    rd(1'b0, r); check("R10 specific EOI line5", r, 8'h00);
    check("R7 line6 released", {7'd0, int_out}, 8'h01);
    ack(3'd0); check("R8 line6 vector", vec_out, 8'h26);
    wr(1'b0, 8'h66);
    wr(1'b0, 8'h0A);
    irq = 8'h00; step(1);

    // R9 spurious acknowledge with line 7 masked
    wr(1'b1, 8'h80);
    irq = 8'h10; step(1);
    check("R9 request seen", {7'd0, int_out}, 8'h01);
    irq = 8'h00; step(1);
    check("R9 request withdrawn", {7'd0, int_out}, 8'h00);
    ack(3'd0);
    check("R9 spurious valid", {7'd0, vec_valid}, 8'h01);
    check("R9 spurious vector", vec_out, 8'h27);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R9 in-service unchanged", r, 8'h00);
    wr(1'b0, 8'h0A);

    // R11 master hands acknowledge to slave on line 2
    wr(1'b1, 8'h00);
    irq = 8'h04; step(1);
    ack(3'd0);
    check("R11 no vector from master", {7'd0, vec_valid}, 8'h00);
    check("R11 cascade valid", {7'd0, cas_valid}, 8'h01);
    check("R11 cascade line", {5'd0, cas_out}, 8'h02);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R11 in-service line2", r, 8'h04);
    wr(1'b0, 8'h62);
    irq = 8'h00; step(1);

    // R12 slave identity 2, base 0x28
    master_sel = 1'b0;
    wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
    wr(1'b1, 8'h00);
    irq = 8'h08; step(1);
    ack(3'd5);
    check("R12 wrong identity silent", {6'd0, vec_valid, cas_valid}, 8'h00);
    rd(1'b0, r); check("R12 request kept", r, 8'h08);
    ack(3'd2);
    check("R12 matching identity vector", vec_out, 8'h2B);
    irq = 8'h00; step(1);

    // R2 R3: single mode, no cascade word, mode word selects auto EOI
    master_sel = 1'b1;
    wr(1'b0, 8'h13);
    irq = 8'h01; step(1);
    check("R2 int_out low during init", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h48); wr(1'b1, 8'h03); wr(1'b1, 8'h00);
    rd(1'b1, r); check("R2 cascade word skipped", r, 8'h00);
    check("R2 int_out after init", {7'd0, int_out}, 8'h01);
    ack(3'd0);
    check("R2 new base vector", vec_out, 8'h48);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R3 auto EOI leaves in-service clear", r, 8'h00);
    irq = 8'h00; step(2);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule